// File: doc/BRIEF.md
# Shadow-Backed SRAM Store Controller

This block fronts a small byte-wide SRAM that is paired word-for-word with a shadow nonvolatile array. Active-low chip-enable, output-enable and write-enable inputs are decoded into ordinary reads and writes. A STORE copies every SRAM byte into the shadow array in a single parallel step. A RECALL copies the shadow array back into the SRAM. A STORE can be started in three ways: a falling edge on the shared store-request line, a one-cycle software strobe, or a supply-fail flag. While a STORE is running, the block pulls that same shared line low.

Everything is synchronous. Analog delays are replaced by cycle-count parameters: a grace window (`GRACE_CYC`), the STORE duration (`STORE_CYC`) and the RECALL duration (`RECALL_CYC`). A modified flag records whether any write has landed since the last STORE or RECALL. Hardware-line and supply-fail STOREs are dropped when that flag is clear. Software STOREs always run.

The sequencer has five states:
- WAIT_RCL: a recall is pending until supply is good.
- RECALL
- IDLE
- GRACE: the hardware-request window.
- STORE

It has these transitions:
- reset to WAIT_RCL.
- WAIT_RCL to RECALL when `pwr_fail` is low.
- RECALL to WAIT_RCL on `pwr_fail`.
- RECALL to IDLE when the count ends.
- IDLE to GRACE on a falling request edge.
- IDLE to STORE on the software strobe.
- IDLE or GRACE to STORE on `pwr_fail` when modified.
- IDLE or GRACE to WAIT_RCL on `pwr_fail` when clean.
- GRACE to STORE at the end of the window when modified.
- GRACE to IDLE at the end of the window when clean.
- STORE to WAIT_RCL when the store was caused by supply fail.
- STORE to IDLE otherwise.

Top module: `nvshadow_ctrl`

## Requirements
- R1: `rdata_vld` is 1, and `rdata` holds the byte at `addr`, only when all of these hold: `cs_n`=0, `oe_n`=0, `we_n`=1, and either (IDLE and the line is high) or GRACE. In every other case `rdata_vld`=0 and `rdata`=0.
- R2: A write opens in IDLE when `cs_n`=0 and `we_n`=0 while the line is high. The address and data latched on the last open cycle are written at the clock edge after `cs_n` or `we_n` returns high.
- R3: No reads are valid and no writes land in WAIT_RCL, RECALL or STORE.
- R4: In IDLE, a falling edge on `req_n_in` opens a GRACE window of `GRACE_CYC` cycles. Reads are serviced during the window. When the window ends, the block enters STORE if the modified flag is set, and returns to IDLE with no busy pulse if it is clear.
- R5: A write already open when the line falls may complete during GRACE. A write started while the line is low does not land.
- R6: A `sw_store` pulse in IDLE starts STORE at the next edge, even when nothing has been written.
- R7: Every STORE holds `busy_pull`=1 for exactly `STORE_CYC` cycles. The shared line level is `req_n_in` AND NOT `busy_pull`.
- R8: The modified flag is set by every landed write and cleared when a STORE or RECALL completes. Hardware-line and supply-fail STOREs happen only when the flag is set.
- R9: `pwr_fail`=1 in IDLE or GRACE does one of two things. If the flag is set, it starts STORE and then moves to WAIT_RCL. If the flag is clear, it goes directly to WAIT_RCL.
- R10: After reset, and whenever `pwr_fail` rises, a RECALL is pending. It runs for `RECALL_CYC` cycles once `pwr_fail` is 0, restarts if `pwr_fail` returns, and copies the shadow array into the SRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears both arrays and pends a recall |
| pwr_fail | input | 1 | Supply below switch threshold |
| cs_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, 0 when not valid |
| rdata_vld | output | 1 | Read data valid (low models high impedance) |
| req_n_in | input | 1 | External drive of the shared store-request line |
| sw_store | input | 1 | Software store strobe |
| busy_pull | output | 1 | Enable for the open-drain pull-down of the shared line |

## Verification
Each fault in the sequencer or the modified flag has a distinct, prompt signature at the ports:
- A stale or wrongly set modified flag shows as a busy pulse that should be missing, or a missing pulse that should be present. This appears within `GRACE_CYC`+1 cycles of a request edge, or one cycle after `pwr_fail`.
- A miscounted grace window or store length shifts when busy rises or how long it lasts, and the bench measures both.
- A wrong access gate shows at once as `rdata_vld` during busy or recall.
- A write that lands when it should not, or fails to land, shows up as the wrong byte on a later read.
- A broken copy path shows as wrong data after the next recall.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [2:0] {
        ST_WAIT_RCL = 3'd0,
        ST_RECALL   = 3'd1,
        ST_IDLE     = 3'd2,
        ST_GRACE    = 3'd3,
        ST_STORE    = 3'd4
    } nvs_state_e;
endpackage

// File: rtl/nvs_cell_array.sv
module nvs_cell_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              do_store,
    input  logic              do_recall
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] sram_q   [DEPTH];
    logic [DATA_W-1:0] shadow_q [DEPTH];

    // volatile side: recall overrides any write (never concurrent in practice)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) sram_q[i] <= '0;
        end else if (do_recall) begin
            for (int i = 0; i < DEPTH; i++) sram_q[i] <= shadow_q[i];
        end else if (wr_en) begin
            sram_q[wr_addr] <= wr_data;
        end
    end

    // nonvolatile side: whole-array parallel copy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) shadow_q[i] <= '0;
        end else if (do_store) begin
            for (int i = 0; i < DEPTH; i++) shadow_q[i] <= sram_q[i];
        end
    end

    assign rd_data = sram_q[rd_addr];
endmodule

// File: rtl/nvs_access.sv
module nvs_access #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              line_hi,
    input  logic              st_idle,
    input  logic              st_grace,
    output logic              rd_vld,
    output logic              wr_commit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic wr_open_q;
    logic allow_new, allow_cont, wr_now;

    assign allow_new  = st_idle && line_hi;
    assign allow_cont = st_idle || st_grace;
    assign wr_now     = !cs_n && !we_n && (wr_open_q ? allow_cont : allow_new);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_open_q <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_open_q <= wr_now;
            if (wr_now) begin
                wr_addr <= addr;
                wr_data <= wdata;
            end
        end
    end

    // write lands on the edge that closes it, unless the array was locked meanwhile
    assign wr_commit = wr_open_q && !wr_now && allow_cont;
    assign rd_vld    = !cs_n && !oe_n && we_n && (allow_new || st_grace);
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int GRACE_CYC  = 4,
    parameter int STORE_CYC  = 6,
    parameter int RECALL_CYC = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_fail,
    input  logic       hw_fall,
    input  logic       sw_store,
    input  logic       commit,
    output nvs_state_e state,
    output logic       do_store,
    output logic       do_recall,
    output logic       dirty_q,
    output logic       busy,
    output logic       st_idle,
    output logic       st_grace
);
    localparam int MAXC_A = (GRACE_CYC > STORE_CYC) ? GRACE_CYC : STORE_CYC;
    localparam int MAXC   = (MAXC_A > RECALL_CYC) ? MAXC_A : RECALL_CYC;
    localparam int CW     = $clog2(MAXC + 1);
    localparam logic [CW-1:0] GR_LAST  = CW'(GRACE_CYC - 1);
    localparam logic [CW-1:0] STO_LAST = CW'(STORE_CYC - 1);
    localparam logic [CW-1:0] RCL_LAST = CW'(RECALL_CYC - 1);

    nvs_state_e st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic pf_q, pf_n;
    logic dirty_n;

    assign dirty_n = dirty_q | commit;

    always_comb begin
        st_n      = st_q;
        cnt_n     = cnt_q;
        pf_n      = pf_q;
        do_store  = 1'b0;
        do_recall = 1'b0;
        unique case (st_q)
            ST_WAIT_RCL: begin
                if (!pwr_fail) begin
                    st_n  = ST_RECALL;
                    cnt_n = RCL_LAST;
                end
            end
            ST_RECALL: begin
                if (pwr_fail) begin
                    st_n = ST_WAIT_RCL;
                end else if (cnt_q == '0) begin
                    do_recall = 1'b1;
                    st_n      = ST_IDLE;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            ST_IDLE: begin
                if (pwr_fail) begin
                    if (dirty_n) begin
                        st_n  = ST_STORE;
                        cnt_n = STO_LAST;
                        pf_n  = 1'b1;
                    end else begin
                        st_n = ST_WAIT_RCL;
                    end
                end else if (hw_fall) begin
                    st_n  = ST_GRACE;
                    cnt_n = GR_LAST;
                end else if (sw_store) begin
                    st_n  = ST_STORE;
                    cnt_n = STO_LAST;
                end
            end
            ST_GRACE: begin
                if (pwr_fail) begin
                    if (dirty_n) begin
                        st_n  = ST_STORE;
                        cnt_n = STO_LAST;
                        pf_n  = 1'b1;
                    end else begin
                        st_n = ST_WAIT_RCL;
                    end
                end else if (cnt_q == '0) begin
                    if (dirty_n) begin
                        st_n  = ST_STORE;
                        cnt_n = STO_LAST;
                    end else begin
                        st_n = ST_IDLE;
                    end
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            ST_STORE: begin
                if (cnt_q == '0) begin
                    do_store = 1'b1;
                    st_n     = (pf_q || pwr_fail) ? ST_WAIT_RCL : ST_IDLE;
                    pf_n     = 1'b0;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            default: st_n = ST_WAIT_RCL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_WAIT_RCL;
            cnt_q   <= '0;
            pf_q    <= 1'b0;
            dirty_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            cnt_q   <= cnt_n;
            pf_q    <= pf_n;
            dirty_q <= (do_store || do_recall) ? 1'b0 : dirty_n;
        end
    end

    // outputs decoded from state
    always_comb begin
        busy     = (st_q == ST_STORE);
        st_idle  = (st_q == ST_IDLE);
        st_grace = (st_q == ST_GRACE);
        state    = st_q;
    end
endmodule

// File: rtl/nvshadow_ctrl.sv
module nvshadow_ctrl
    import nvs_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int GRACE_CYC  = 4,
    parameter int STORE_CYC  = 6,
    parameter int RECALL_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_fail,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld,
    input  logic              req_n_in,
    input  logic              sw_store,
    output logic              busy_pull
);
    nvs_state_e        state;
    logic              do_store, do_recall, dirty_q;
    logic              st_idle, st_grace;
    logic              wr_commit;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] arr_rd;
    logic              req_q, hw_fall, line_hi, rd_vld;

    // shared line: wired AND of external drive and internal pull-down
    assign line_hi = req_n_in && !busy_pull;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b1;
        else        req_q <= req_n_in;
    end
    assign hw_fall = req_q && !req_n_in;

    nvs_seq #(
        .GRACE_CYC (GRACE_CYC),
        .STORE_CYC (STORE_CYC),
        .RECALL_CYC(RECALL_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_fail (pwr_fail),
        .hw_fall  (hw_fall),
        .sw_store (sw_store),
        .commit   (wr_commit),
        .state    (state),
        .do_store (do_store),
        .do_recall(do_recall),
        .dirty_q  (dirty_q),
        .busy     (busy_pull),
        .st_idle  (st_idle),
        .st_grace (st_grace)
    );

    nvs_access #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .addr     (addr),
        .wdata    (wdata),
        .line_hi  (line_hi),
        .st_idle  (st_idle),
        .st_grace (st_grace),
        .rd_vld   (rd_vld),
        .wr_commit(wr_commit),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    nvs_cell_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_commit),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (addr),
        .rd_data  (arr_rd),
        .do_store (do_store),
        .do_recall(do_recall)
    );

    assign rdata_vld = rd_vld;
    assign rdata     = rd_vld ? arr_rd : '0;
endmodule

// File: rtl/nvshadow_chk.sv
module nvshadow_chk #(
    parameter int STORE_CYC = 6
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic oe_n,
    input logic we_n,
    input logic rdata_vld,
    input logic busy_pull,
    input logic sw_store,
    input logic commit,
    input logic dirty_q
);
    // R1
    rd_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_vld |-> (!cs_n && !oe_n && we_n));

    // R3
    rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_pull |-> !rdata_vld);

    // R3
    wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_pull |-> !commit);

    // R8
    store_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_pull) |-> $past(sw_store || dirty_q || commit));

    // R8
    clean_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_pull) |-> !dirty_q);

    generate
        if (STORE_CYC > 1) begin : g_len
            // R7
            busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(busy_pull) |=> busy_pull);
        end
    endgenerate
endmodule

bind nvshadow_ctrl nvshadow_chk #(.STORE_CYC(STORE_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .rdata_vld(rdata_vld),
    .busy_pull(busy_pull),
    .sw_store (sw_store),
    .commit   (wr_commit),
    .dirty_q  (dirty_q)
);

// File: tb/nvshadow_ctrl_test.sv
module nvshadow_ctrl_test;
    localparam int AW = 4, DW = 8, GR = 4, ST = 6, RC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_fail = 1'b0;
    logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rdata_vld;
    logic req_n_in = 1'b1;
    logic sw_store = 1'b0;
    logic busy_pull;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    nvshadow_ctrl #(.ADDR_W(AW), .DATA_W(DW), .GRACE_CYC(GR),
                    .STORE_CYC(ST), .RECALL_CYC(RC)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_vld(rdata_vld), .req_n_in(req_n_in),
        .sw_store(sw_store), .busy_pull(busy_pull)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a,
                          input int exp_vld, input int exp_d);
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        #1;
        chk(req, int'(rdata_vld), exp_vld);
        chk(req, int'(rdata), exp_d);
        cs_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic watch_busy(input int n, output int first, output int total);
        first = -1; total = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (busy_pull) begin
                total++;
                if (first < 0) first = i;
            end
        end
    endtask

    task automatic t_reset();
        idle_n(3);
        rst_n = 1'b1;
        #1;
        chk("R10 busy at reset", int'(busy_pull), 0);
        cs_n = 1'b0; oe_n = 1'b0; #1;
        chk("R3 read while recall pending", int'(rdata_vld), 0);
        chk("R1 rdata zero when invalid", int'(rdata), 0);
        cs_n = 1'b1; oe_n = 1'b1;
        idle_n(RC + 3);
        rd_chk("R10 recall of blank shadow", 4'd3, 1, 0);
    endtask

    task automatic t_rw();
        wr(4'd1, 8'h3C);
        wr(4'd2, 8'h22);
        wr(4'd15, 8'hA7);
        rd_chk("R2 readback addr1", 4'd1, 1, 8'h3C);
        rd_chk("R2 readback addr2", 4'd2, 1, 8'h22);
        rd_chk("R2 readback addr15", 4'd15, 1, 8'hA7);
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b1; addr = 4'd1; #1;
        chk("R1 oe_n high no read", int'(rdata_vld), 0);
        oe_n = 1'b0; we_n = 1'b0; wdata = 8'h3C; #1;
        chk("R1 we_n low no read", int'(rdata_vld), 0);
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_sw_store();
        int first, total;
        @(negedge clk);
        sw_store = 1'b1;
        @(negedge clk);
        sw_store = 1'b0;
        chk("R6 busy next cycle after strobe", int'(busy_pull), 1);
        cs_n = 1'b0; oe_n = 1'b0; addr = 4'd1; #1;
        chk("R3 read blocked in store", int'(rdata_vld), 0);
        cs_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b0; addr = 4'd2; wdata = 8'hEE;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
        watch_busy(10, first, total);
        chk("R7 store length", total + 3, ST);
        rd_chk("R3 write in store ignored", 4'd2, 1, 8'h22);
    endtask

    task automatic t_sw_clean();
        int first, total;
        @(negedge clk);
        sw_store = 1'b1;
        @(negedge clk);
        sw_store = 1'b0;
        watch_busy(10, first, total);
        chk("R6 clean software store runs", total + int'(first == 1 ? 0 : 0), ST - 1);
    endtask

    task automatic t_hw_clean();
        int first, total;
        @(negedge clk);
        req_n_in = 1'b0;
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0; addr = 4'd15; #1;
        chk("R4 read valid in grace", int'(rdata_vld), 1);
        chk("R4 read data in grace", int'(rdata), 8'hA7);
        cs_n = 1'b1; oe_n = 1'b1;
        watch_busy(12, first, total);
        chk("R8 clean hw request skipped", total, 0);
        cs_n = 1'b0; oe_n = 1'b0; #1;
        chk("R1 line low in idle no read", int'(rdata_vld), 0);
        cs_n = 1'b1; oe_n = 1'b1;
        req_n_in = 1'b1;
        idle_n(2);
    endtask

    task automatic t_hw_dirty();
        int first, total;
        wr(4'd4, 8'h44);
        @(negedge clk);
        req_n_in = 1'b0;
        watch_busy(16, first, total);
        chk("R4 busy after grace window", first, GR + 1);
        chk("R7 hw store length", total, ST);
        req_n_in = 1'b1;
        idle_n(2);
    endtask

    task automatic t_grace_write();
        int first, total;
        wr(4'd6, 8'h11);
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b0; addr = 4'd5; wdata = 8'hA5;
        @(negedge clk);
        req_n_in = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b0; addr = 4'd6; wdata = 8'h66;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
        watch_busy(14, first, total);
        chk("R7 grace store length", total, ST);
        req_n_in = 1'b1;
        idle_n(2);
        rd_chk("R5 open write finished in grace", 4'd5, 1, 8'hA5);
        rd_chk("R5 new write in grace blocked", 4'd6, 1, 8'h11);
    endtask

    task automatic t_pf_dirty();
        int first, total;
        wr(4'd7, 8'h77);
        @(negedge clk);
        pwr_fail = 1'b1;
        watch_busy(10, first, total);
        chk("R9 autostore starts at once", first, 1);
        chk("R9 autostore length", total, ST);
        rd_chk("R10 no read while supply low", 4'd7, 0, 0);
        @(negedge clk);
        pwr_fail = 1'b0;
        idle_n(RC + 3);
        rd_chk("R10 recall restores stored data", 4'd7, 1, 8'h77);
        rd_chk("R10 recall keeps grace write", 4'd5, 1, 8'hA5);
    endtask

    task automatic t_pf_clean();
        int first, total;
        @(negedge clk);
        pwr_fail = 1'b1;
        watch_busy(10, first, total);
        chk("R8 clean power-fail store skipped", total, 0);
        pwr_fail = 1'b0;
        idle_n(2);
        pwr_fail = 1'b1;
        idle_n(RC + 2);
        rd_chk("R10 recall restarts on new fail", 4'd7, 0, 0);
        pwr_fail = 1'b0;
        idle_n(RC + 3);
        rd_chk("R9 data after clean fail", 4'd7, 1, 8'h77);
        rd_chk("R9 data addr1 preserved", 4'd1, 1, 8'h3C);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_rw();
        t_sw_store();
        t_sw_clean();
        t_hw_clean();
        t_hw_dirty();
        t_grace_write();
        t_pf_dirty();
        t_pf_clean();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule